// File: doc/BRIEF.md
# Banked Prioritized Interrupt Controller

This block collects interrupt sources in four byte-wide banks and presents one winning source number to a host processor. The low-priority bank latches rising edges and keeps them until software clears them. The high-priority bank, the DMA bank and the fast-interrupt bank follow their input levels. Every bank has an enable mask, and a source only requests service when its status bit and its mask bit are both set.

The three banks that feed the normal interrupt line are searched in a fixed order. The high-priority bank is searched first, then the DMA bank, then the low-priority bank. Inside each bank a fixed priority order is used, and that order is not simply lowest-bit-first. The result is a valid flag and a 5-bit source number, and the host services interrupts by reading that number. The fast-interrupt bank is not encoded: it drives a separate line that is the OR of its enabled requests.

The host reaches the registers through a single-cycle byte port. Writes take effect on the clock edge. Reads are combinational on the address.

Top module: `prio_intc`

## Requirements
- R1: Address bits [5:4] select the bank: 0 is the low-priority bank A, 1 is the high-priority bank B, 2 is DMA and 3 is FIQ. Address bits [3:0] select the register inside the bank: 0x0 is raw status (read only), 0x4 is masked request on read and clear on write, and 0x8 is the mask (read/write). Every other offset reads as zero.
- R2: The request value of a bank is its status ANDed with its mask. Any source whose mask bit is 0 takes no part in the winner search and does not drive an output.
- R3: A rising edge on `src_a[i]` sets status bit i of bank A at the next clock edge. The bit then stays set until a write to address 0x04 carries a one in bit i. If an edge arrives in the same cycle as that clear, the set wins.
- R4: The status of bank B, DMA and FIQ follows the input level directly. Writes to the clear offsets of these banks (0x14, 0x24, 0x34) have no effect.
- R5: Bank B is searched first, then DMA, then bank A. A lower bank is used only when every bank above it has no request.
- R6: Inside bank A the priority from highest to lowest is bit 7, 5, 3, 6, 2, 0, 1, 4. The reported number is the bit index.
- R7: Inside bank B the priority from highest to lowest is bit 2, 3, 5, 7, 6, 0, 1, 4. The reported number is 8 plus the bit index.
- R8: Inside the DMA bank the priority from highest to lowest is bit 0, 1, 2, 3, 5, 4. The reported number is 16 plus the bit index. Only bits 0 to 5 have inputs, so DMA status bits 6 and 7 read as zero.
- R9: `irq_o` is high exactly when some enabled request exists in bank A, bank B or DMA. When `irq_o` is low, `irq_id` is 0.
- R10: `fiq_o` is the OR of the FIQ status ANDed with the FIQ mask. The FIQ bank never affects `irq_o` or `irq_id`.
- R11: Reset clears all four masks and all of the bank A status. After reset, no output is asserted even when the level inputs are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a | input | 8 | Edge-triggered sources of bank A |
| src_b | input | 8 | Level sources of bank B |
| src_dma | input | 6 | Level sources of the DMA bank |
| src_fiq | input | 8 | Level sources of the FIQ bank |
| bus_addr | input | 6 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_o | output | 1 | An enabled normal request exists |
| irq_id | output | 5 | Number of the winning source |
| fiq_o | output | 1 | Fast-interrupt request |

## Verification
The hardest case to reach is the exact moment at which bank A loses or keeps a bit. A clear write and a new rising edge must land on the same clock edge, and the input must first be low for a full cycle so that an edge can occur at all. The bench gets there in a set order: it lowers the input, latches an edge, and then raises the input again in the same cycle that the clear strobe is driven. It then reads back the status to confirm the bit survived. The non-monotonic orders are covered by sweeping all 256 patterns of every 8-bit bank, with bank A filled through real edges after a full clear. Every result is compared against a search written directly from the priority lists.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int BW   = 8;
  localparam int IW   = $clog2(BW);
  localparam int AW   = 6;
  localparam int IDW  = 5;

  localparam logic [1:0] BK_A = 2'd0;
  localparam logic [1:0] BK_B = 2'd1;
  localparam logic [1:0] BK_D = 2'd2;
  localparam logic [1:0] BK_F = 2'd3;

  localparam logic [3:0] OFS_STAT = 4'h0;
  localparam logic [3:0] OFS_REQ  = 4'h4;
  localparam logic [3:0] OFS_MASK = 4'h8;

  // Priority lists, highest priority in the most significant slot.
  localparam logic [BW*IW-1:0] ORDER_A = {3'd7, 3'd5, 3'd3, 3'd6, 3'd2, 3'd0, 3'd1, 3'd4};
  localparam logic [BW*IW-1:0] ORDER_B = {3'd2, 3'd3, 3'd5, 3'd7, 3'd6, 3'd0, 3'd1, 3'd4};
  localparam logic [BW*IW-1:0] ORDER_D = {3'd0, 3'd1, 3'd2, 3'd3, 3'd5, 3'd6, 3'd7, 3'd4};

  typedef struct packed {
    logic          hit;
    logic [IW-1:0] idx;
  } pick_t;
endpackage

// File: rtl/intc_edge_bank.sv
module intc_edge_bank
  import prio_intc_pkg::*;
#(
  parameter int W = BW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] stat
);
  logic [W-1:0] prev_q, prev_d;
  logic [W-1:0] stat_q, stat_d;
  logic [W-1:0] rise;
  logic [W-1:0] clr_eff;

  always_comb begin
    rise    = src & ~prev_q;
    clr_eff = clr_we ? clr_bits : '0;
    stat_d  = (stat_q & ~clr_eff) | rise;   // a new edge beats a clear
    prev_d  = src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= prev_d;
      stat_q <= stat_d;
    end
  end

  assign stat = stat_q;
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick
  import prio_intc_pkg::*;
#(
  parameter int               W     = BW,
  parameter logic [W*IW-1:0]  ORDER = ORDER_A
) (
  input  logic [W-1:0] req,
  output pick_t        pick
);
  always_comb begin
    pick.hit = |req;
    pick.idx = '0;
    // Walk from the lowest-priority slot upward; the last match wins.
    for (int k = 0; k < W; k++) begin
      if (req[ORDER[k*IW +: IW]]) pick.idx = ORDER[k*IW +: IW];
    end
  end
endmodule

// File: rtl/intc_resolver.sv
module intc_resolver
  import prio_intc_pkg::*;
(
  input  logic [BW-1:0]  req_a,
  input  logic [BW-1:0]  req_b,
  input  logic [BW-1:0]  req_d,
  output logic           valid,
  output logic [IDW-1:0] id
);
  pick_t pk [3];
  logic [BW*IW-1:0] orders [3];
  logic [BW-1:0]    reqs   [3];

  assign reqs[0] = req_b;
  assign reqs[1] = req_d;
  assign reqs[2] = req_a;

  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : g_pick
      localparam logic [BW*IW-1:0] ORD = (g == 0) ? ORDER_B : (g == 1) ? ORDER_D : ORDER_A;
      intc_prio_pick #(.W(BW), .ORDER(ORD)) u_pick (
        .req  (reqs[g]),
        .pick (pk[g])
      );
      assign orders[g] = ORD;
    end
  endgenerate

  always_comb begin
    valid = 1'b0;
    id    = '0;
    if (pk[0].hit) begin
      valid = 1'b1;
      id    = {2'b01, pk[0].idx};
    end else if (pk[1].hit) begin
      valid = 1'b1;
      id    = {2'b10, pk[1].idx};
    end else if (pk[2].hit) begin
      valid = 1'b1;
      id    = {2'b00, pk[2].idx};
    end
  end

  logic unused_ord;
  assign unused_ord = ^{orders[0], orders[1], orders[2]};
endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
  import prio_intc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [BW-1:0] wdata,
  input  logic [BW-1:0] stat_a,
  input  logic [BW-1:0] stat_b,
  input  logic [BW-1:0] stat_d,
  input  logic [BW-1:0] stat_f,
  output logic [BW-1:0] mask_a,
  output logic [BW-1:0] mask_b,
  output logic [BW-1:0] mask_d,
  output logic [BW-1:0] mask_f,
  output logic          clr_a_we,
  output logic [BW-1:0] rdata
);
  logic [1:0]          bank;
  logic [3:0]          ofs;
  logic [3:0][BW-1:0]  mask_q;
  logic [3:0][BW-1:0]  mask_d_n;
  logic [3:0][BW-1:0]  stat_v;

  assign bank   = addr[5:4];
  assign ofs    = addr[3:0];
  assign stat_v = {stat_f, stat_d, stat_b, stat_a};

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_mask
      logic en;
      assign en = we && (ofs == OFS_MASK) && (bank == 2'(g));
      always_comb mask_d_n[g] = en ? wdata : mask_q[g];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q[g] <= '0;
        else        mask_q[g] <= mask_d_n[g];
      end
    end
  endgenerate

  assign mask_a   = mask_q[BK_A];
  assign mask_b   = mask_q[BK_B];
  assign mask_d   = mask_q[BK_D];
  assign mask_f   = mask_q[BK_F];
  assign clr_a_we = we && (bank == BK_A) && (ofs == OFS_REQ);

  always_comb begin
    case (ofs)
      OFS_STAT: rdata = stat_v[bank];
      OFS_REQ:  rdata = stat_v[bank] & mask_q[bank];
      OFS_MASK: rdata = mask_q[bank];
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int DMA_SRCS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BW-1:0]       src_a,
  input  logic [BW-1:0]       src_b,
  input  logic [DMA_SRCS-1:0] src_dma,
  input  logic [BW-1:0]       src_fiq,
  input  logic [AW-1:0]       bus_addr,
  input  logic                bus_we,
  input  logic [BW-1:0]       bus_wdata,
  output logic [BW-1:0]       bus_rdata,
  output logic                irq_o,
  output logic [IDW-1:0]      irq_id,
  output logic                fiq_o
);
  logic [BW-1:0] stat_a, stat_d;
  logic [BW-1:0] mask_a, mask_b, mask_d, mask_f;
  logic          clr_a_we;

  assign stat_d = {{(BW-DMA_SRCS){1'b0}}, src_dma};

  intc_edge_bank #(.W(BW)) u_bank_a (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (src_a),
    .clr_we   (clr_a_we),
    .clr_bits (bus_wdata),
    .stat     (stat_a)
  );

  intc_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .we       (bus_we),
    .wdata    (bus_wdata),
    .stat_a   (stat_a),
    .stat_b   (src_b),
    .stat_d   (stat_d),
    .stat_f   (src_fiq),
    .mask_a   (mask_a),
    .mask_b   (mask_b),
    .mask_d   (mask_d),
    .mask_f   (mask_f),
    .clr_a_we (clr_a_we),
    .rdata    (bus_rdata)
  );

  intc_resolver u_res (
    .req_a (stat_a & mask_a),
    .req_b (src_b & mask_b),
    .req_d (stat_d & mask_d),
    .valid (irq_o),
    .id    (irq_id)
  );

  assign fiq_o = |(src_fiq & mask_f);
endmodule

// File: rtl/prio_intc_sva.sv
module prio_intc_sva
  import prio_intc_pkg::*;
#(
  parameter int DMA_SRCS = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic [BW-1:0]  src_b,
  input logic [BW-1:0]  src_fiq,
  input logic [BW-1:0]  stat_a,
  input logic [BW-1:0]  stat_d,
  input logic [BW-1:0]  mask_a,
  input logic [BW-1:0]  mask_b,
  input logic [BW-1:0]  mask_d,
  input logic [BW-1:0]  mask_f,
  input logic           clr_a_we,
  input logic           irq_o,
  input logic [IDW-1:0] irq_id,
  input logic           fiq_o
);
  // R3: without a clear strobe, no latched bit of bank A is lost
  a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_a_we |=> ((stat_a & $past(stat_a)) == $past(stat_a)));

  // R5: any enabled bank B request makes bank B the winner
  a_r5_b_first: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_b & mask_b)) |-> (irq_o && irq_id[4:3] == 2'b01));

  // R8: DMA winners come only from wired inputs
  a_r8_dma_range: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_id[4]) |-> (!irq_id[3] && int'(irq_id[2:0]) < DMA_SRCS));

  // R9: idle means no valid flag and a zero number
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_b & mask_b) == '0 && (stat_d & mask_d) == '0 && (stat_a & mask_a) == '0)
      |-> (!irq_o && irq_id == '0));

  // R10: the fast line needs both a live source and an enable
  a_r10_fiq_src: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> (src_fiq != '0 && mask_f != '0));
endmodule

bind prio_intc prio_intc_sva #(.DMA_SRCS(DMA_SRCS)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_b    (src_b),
  .src_fiq  (src_fiq),
  .stat_a   (stat_a),
  .stat_d   (stat_d),
  .mask_a   (mask_a),
  .mask_b   (mask_b),
  .mask_d   (mask_d),
  .mask_f   (mask_f),
  .clr_a_we (clr_a_we),
  .irq_o    (irq_o),
  .irq_id   (irq_id),
  .fiq_o    (fiq_o)
);

// File: tb/prio_intc_test.sv
module prio_intc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_a = '0, src_b = '0, src_fiq = '0;
  logic [5:0] src_dma = '0;
  logic [5:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_o, fiq_o;
  logic [4:0] irq_id;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  prio_intc uut (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .src_dma(src_dma),
    .src_fiq(src_fiq), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .irq_id(irq_id), .fiq_o(fiq_o)
  );

  int ord_a[8] = '{7, 5, 3, 6, 2, 0, 1, 4};
  int ord_b[8] = '{2, 3, 5, 7, 6, 0, 1, 4};
  int ord_d[6] = '{0, 1, 2, 3, 5, 4};

  // Expected winner from the requirement lists; -1 means idle.
  function automatic int exp_id(input logic [7:0] ra, input logic [7:0] rb, input logic [7:0] rd);
    for (int k = 0; k < 8; k++) if (rb[ord_b[k]]) return 8 + ord_b[k];
    for (int k = 0; k < 6; k++) if (rd[ord_d[k]]) return 16 + ord_d[k];
    for (int k = 0; k < 8; k++) if (ra[ord_a[k]]) return ord_a[k];
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_win(input string tag, input int e);
    if (e < 0) chk(!irq_o && irq_id == 0, tag, {irq_o, irq_id}, 0);
    else       chk(irq_o && int'(irq_id) == e, tag, {irq_o, irq_id}, 32 + e);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    src_b = 8'hFF; src_fiq = 8'hFF; src_dma = 6'h3F;
    #1;
    chk(!irq_o && !fiq_o, "R11 no outputs after reset", {irq_o, fiq_o}, 0);
    for (int b = 0; b < 4; b++) begin
      rd(6'(b * 16 + 8), v);
      chk(v == 0, "R11 mask reset", v, 0);
    end
    rd(6'h00, v);
    chk(v == 0, "R11 bank A status reset", v, 0);
    rd(6'h1C, v);
    chk(v == 0, "R1 unused offset reads zero", v, 0);
    rd(6'h20, v);
    chk(v == 8'h3F, "R8 DMA status upper bits zero", v, 8'h3F);
    src_b = 0; src_fiq = 0; src_dma = 0;
  endtask

  task automatic t_bank_b;
    logic [7:0] v;
    wr(6'h18, 8'hFF);
    for (int p = 0; p < 256; p++) begin
      @(negedge clk); src_b = 8'(p); #1;
      chk_win("R7 bank B order", exp_id(0, 8'(p), 0));
    end
    wr(6'h18, 8'h0F);
    src_b = 8'hA5;
    rd(6'h14, v);
    chk(v == 8'h05, "R2 bank B request read", v, 8'h05);
    rd(6'h10, v);
    chk(v == 8'hA5, "R4 bank B status follows level", v, 8'hA5);
    src_b = 8'h04;
    wr(6'h14, 8'hFF);
    #1 chk_win("R4 bank B clear write ignored", 10);
    src_b = 0; wr(6'h18, 8'h00);
  endtask

  task automatic t_dma;
    wr(6'h28, 8'hFF);
    for (int p = 0; p < 64; p++) begin
      @(negedge clk); src_dma = 6'(p); #1;
      chk_win("R8 DMA order", exp_id(0, 0, {2'b00, 6'(p)}));
    end
    src_dma = 6'h10;
    wr(6'h24, 8'hFF);
    #1 chk_win("R4 DMA clear write ignored", 20);
    src_dma = 0; wr(6'h28, 8'h00);
  endtask

  task automatic t_bank_a;
    logic [7:0] v;
    wr(6'h08, 8'hFF);
    for (int p = 0; p < 256; p++) begin
      @(negedge clk); src_a = 0;
      wr(6'h04, 8'hFF);
      src_a = 8'(p);
      @(negedge clk); #1;
      chk_win("R6 bank A order", exp_id(8'(p), 0, 0));
    end
    src_a = 0;
    repeat (3) @(negedge clk);
    rd(6'h00, v);
    chk(v == 8'hFF, "R3 status holds after inputs drop", v, 8'hFF);
    wr(6'h04, 8'h81);
    rd(6'h00, v);
    chk(v == 8'h7E, "R3 clear writes ones only", v, 8'h7E);
    wr(6'h08, 8'h0C);
    rd(6'h04, v);
    chk(v == 8'h0C, "R2 bank A request read", v, 8'h0C);
    // Same-cycle edge and clear on bit 0 after a full clear.
    wr(6'h04, 8'hFF);
    src_a = 8'h01;
    @(negedge clk);
    src_a = 8'h00;
    @(negedge clk);
    bus_addr = 6'h04; bus_wdata = 8'h01; bus_we = 1'b1; src_a = 8'h01;
    @(negedge clk);
    bus_we = 1'b0;
    rd(6'h00, v);
    chk(v == 8'h01, "R3 set wins over clear", v, 8'h01);
    wr(6'h04, 8'h01);
    rd(6'h00, v);
    chk(v == 8'h00, "R3 clear without edge", v, 8'h00);
    src_a = 0; wr(6'h08, 8'h00);
  endtask

  task automatic t_cross;
    wr(6'h08, 8'hFF); wr(6'h18, 8'hFF); wr(6'h28, 8'hFF);
    src_a = 8'h80;
    src_dma = 6'h01; src_b = 8'h10;
    @(negedge clk); #1;
    chk_win("R5 bank B beats DMA and A", 12);
    src_b = 0; #1;
    chk_win("R5 DMA beats bank A", 16);
    src_dma = 0; #1;
    chk_win("R5 bank A last", 7);
    wr(6'h08, 8'h00);
    #1 chk_win("R2 masked A idle", -1);
    wr(6'h18, 8'h00);
    src_b = 8'h01; src_dma = 6'h08; #1;
    chk_win("R2 masked B skipped", 19);
    src_b = 0; src_dma = 0; #1;
    chk_win("R9 idle number zero", -1);
    wr(6'h04, 8'hFF); src_a = 0; wr(6'h28, 8'h00);
  endtask

  task automatic t_fiq;
    wr(6'h38, 8'h10);
    src_fiq = 8'h20; #1;
    chk(!fiq_o, "R10 fiq masked source", fiq_o, 0);
    src_fiq = 8'h30; #1;
    chk(fiq_o, "R10 fiq enabled source", fiq_o, 1);
    chk_win("R10 fiq does not touch irq", -1);
    wr(6'h34, 8'hFF);
    #1 chk(fiq_o, "R4 fiq clear write ignored", fiq_o, 1);
    src_fiq = 0; #1;
    chk(!fiq_o, "R10 fiq drops with level", fiq_o, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bank_b();
    t_dma();
    t_bank_a();
    t_cross();
    t_fiq();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule